// File: doc/BRIEF.md
# Soft-Start and Fault Response Sequencer

This block is the supervisory state machine of a switching power supply controller. It holds the converter off until the configuration load reports completion, then, when power-on is requested, raises a regulation reference from zero to a programmed target in fixed increments. Each increment is paced by a programmable prescaler. The PWM generator and loop filter downstream follow the reference and the PWM enable, and are not part of this block.

While the reference is rising, only the fast overcurrent flag can act. When that flag is not blanked, it throws the reference back to zero and restarts the whole ramp. Every other fault flag is held off until the ramp completes. In normal operation, each flag (internal, fast overcurrent, or the external fault pin) is either ignored, reported only, or reported with a shutdown response. A shutdown, whether caused by a fault or by removing the power-on request, either drops the reference at once or ramps it down. The ramp-down uses the same step and prescaler as the ramp-up, so both take the same time.

Present flags appear in a primary flag vector. Each flag also sets a sticky latched bit, which a clear strobe removes only once the flag has gone away.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is held, `seq_state` is 0 (RESET), `ref_out` is 0 and `pwm_en` is 0. One clock after reset is released, the state is 1 (LOAD), and it stays there while `load_done` is low.
- R2: In LOAD, `load_done` high moves the block to 3 (SOFT_START) if `power_on_req` is high, and otherwise to 2 (IDLE). From IDLE, `power_on_req` high moves it to SOFT_START.
- R3: In SOFT_START, every prescaler tick (one tick per `tick_div`+1 clocks) raises `ref_out` by `ref_step`, clamped to `ref_target`. The state lasts exactly ceil(target/step)×(`tick_div`+1) clocks and then becomes 4 (RUN), with `ref_out` equal to the target.
- R4: In SOFT_START, a fast overcurrent (flag bit 0) that is neither ignored nor blanked sets `ref_out` to 0 on the next clock and restarts the full ramp timing.
- R5: With `fast_ocp_blank` high, the fast overcurrent has no effect on the ramp in SOFT_START.
- R6: In SOFT_START, no flag other than the fast overcurrent changes the state or the ramp timing.
- R7: In RUN, a present, non-ignored flag whose `flag_shutdown` bit is set starts a shutdown on the next clock. A flag with a clear `flag_shutdown` bit leaves the state at RUN.
- R8: A shutdown, caused by a fault or by `power_on_req` going low in RUN, goes to 5 (SOFT_STOP) when `soft_stop_en` is high. There `ref_out` falls by `ref_step` per tick and reaches 0 after the same number of clocks as the soft start, then the state becomes 6 (OFF). With `soft_stop_en` low, the block goes to OFF directly. In OFF, `ref_out` is 0.
- R9: `flag_now` equals the raw flag vector with the `flag_ignore` bits cleared. Raw bit 0 is fast overcurrent, bits NF..1 are `int_flags`, and bit NF+1 is `ext_fault`. An ignored flag causes no shutdown.
- R10: Each `flag_now` bit sets the matching `flag_latched` bit, which stays set. A `lat_clr` pulse clears only those latched bits whose flag is absent.
- R11: `ext_fault` is handled like an internal flag, through its own ignore and shutdown bits.
- R12: `pwm_en` is high exactly in SOFT_START, RUN and SOFT_STOP.
- R13: From OFF, the block returns to IDLE once `power_on_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_done | input | 1 | Configuration load complete |
| power_on_req | input | 1 | Request to power the converter |
| soft_stop_en | input | 1 | Ramp the reference down on shutdown |
| fast_ocp_blank | input | 1 | Blank fast overcurrent during soft start |
| ref_target | input | RW | Final reference value |
| ref_step | input | RW | Reference change per tick |
| tick_div | input | DW | Prescaler terminal count |
| fast_ocp | input | 1 | Fast overcurrent flag |
| int_flags | input | NF | Other internal fault flags |
| ext_fault | input | 1 | External fault input |
| flag_ignore | input | NF+2 | Per-flag ignore |
| flag_shutdown | input | NF+2 | Per-flag shutdown response |
| lat_clr | input | 1 | Clear latched flags no longer present |
| ref_out | output | RW | Regulation reference |
| pwm_en | output | 1 | PWM outputs allowed |
| seq_state | output | 3 | Sequencer state code |
| flag_now | output | NF+2 | Present, non-ignored flags |
| flag_latched | output | NF+2 | Sticky flag record |

## Verification
A wrong state shows up on `seq_state` and `pwm_en` on the very next clock. A wrong ramp count or a missed restart changes how many clocks the soft-start or soft-stop state lasts, so the bench counts those clocks exactly. A flag that leaks through the soft-start masking ends the ramp early or moves the block to a stop state, which the clock count also reveals. A latch error appears on `flag_latched` one clock after a flag or clear pulse.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_LOAD   = 3'd1,
    ST_IDLE   = 3'd2,
    ST_SSTART = 3'd3,
    ST_RUN    = 3'd4,
    ST_SSTOP  = 3'd5,
    ST_OFF    = 3'd6
  } seq_state_t;
endpackage

// File: rtl/pwr_seq_tick.sv
// Prescaler: one tick every div+1 clocks, restarted by clr.
module pwr_seq_tick #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt_q;

  assign tick = !clr && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr || tick)  cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwr_seq_ramp.sv
// Reference register with clamped up/down stepping.
module pwr_seq_ramp #(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zero,
  input  logic          up,
  input  logic          down,
  input  logic          tick,
  input  logic [RW-1:0] target,
  input  logic [RW-1:0] step,
  output logic [RW-1:0] ref_o,
  output logic          top_hit,
  output logic          bottom_hit
);
  function automatic logic [RW-1:0] step_up(input logic [RW-1:0] cur,
                                            input logic [RW-1:0] stp,
                                            input logic [RW-1:0] tgt);
    if (cur >= tgt)       return tgt;
    if (tgt - cur <= stp) return tgt;
    return cur + stp;
  endfunction

  function automatic logic [RW-1:0] step_down(input logic [RW-1:0] cur,
                                              input logic [RW-1:0] stp);
    if (cur <= stp) return '0;
    return cur - stp;
  endfunction

  logic [RW-1:0] ref_q, nxt_up, nxt_dn;

  assign nxt_up     = step_up(ref_q, step, target);
  assign nxt_dn     = step_down(ref_q, step);
  assign top_hit    = tick && up && (nxt_up == target);
  assign bottom_hit = tick && down && (nxt_dn == '0);
  assign ref_o      = ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              ref_q <= '0;
    else if (zero)           ref_q <= '0;
    else if (tick && up)     ref_q <= nxt_up;
    else if (tick && down)   ref_q <= nxt_dn;
  end
endmodule

// File: rtl/pwr_seq_flags.sv
// Flag masking, shutdown decision and sticky record.
module pwr_seq_flags #(
  parameter int NT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] raw,
  input  logic [NT-1:0] ignore,
  input  logic [NT-1:0] shut_mask,
  input  logic          lat_clr,
  output logic [NT-1:0] now,
  output logic [NT-1:0] latched,
  output logic          shut_hit
);
  logic [NT-1:0] lat_q;

  assign now      = raw & ~ignore;
  assign shut_hit = |(now & shut_mask);
  assign latched  = lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       lat_q <= '0;
    else if (lat_clr) lat_q <= now;
    else              lat_q <= lat_q | now;
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int RW = 12,
  parameter int DW = 8,
  parameter int NF = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_done,
  input  logic            power_on_req,
  input  logic            soft_stop_en,
  input  logic            fast_ocp_blank,
  input  logic [RW-1:0]   ref_target,
  input  logic [RW-1:0]   ref_step,
  input  logic [DW-1:0]   tick_div,
  input  logic            fast_ocp,
  input  logic [NF-1:0]   int_flags,
  input  logic            ext_fault,
  input  logic [NF+1:0]   flag_ignore,
  input  logic [NF+1:0]   flag_shutdown,
  input  logic            lat_clr,
  output logic [RW-1:0]   ref_out,
  output logic            pwm_en,
  output logic [2:0]      seq_state,
  output logic [NF+1:0]   flag_now,
  output logic [NF+1:0]   flag_latched
);
  localparam int NT = NF + 2;

  seq_state_t    st_q, st_d, stop_st;
  logic [NT-1:0] raw_flags;
  logic          shut_hit, tick, top_hit, bottom_hit;
  logic          fast_act, shut_evt, ramp_zero, ramp_up, ramp_dn, tick_clr;

  assign raw_flags = {ext_fault, int_flags, fast_ocp};

  pwr_seq_flags #(.NT(NT)) u_flags (
    .clk(clk), .rst_n(rst_n), .raw(raw_flags), .ignore(flag_ignore),
    .shut_mask(flag_shutdown), .lat_clr(lat_clr), .now(flag_now),
    .latched(flag_latched), .shut_hit(shut_hit)
  );

  // Named events for the checker.
  assign fast_act = (st_q == ST_SSTART) && flag_now[0] && !fast_ocp_blank;
  assign shut_evt = (st_q == ST_RUN) && (shut_hit || !power_on_req);
  assign stop_st  = soft_stop_en ? ST_SSTOP : ST_OFF;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RESET:  st_d = ST_LOAD;
      ST_LOAD:   if (load_done) st_d = power_on_req ? ST_SSTART : ST_IDLE;
      ST_IDLE:   if (power_on_req) st_d = ST_SSTART;
      ST_SSTART: begin
        if (!power_on_req)  st_d = stop_st;
        else if (fast_act)  st_d = ST_SSTART;
        else if (top_hit)   st_d = ST_RUN;
      end
      ST_RUN:    if (shut_evt) st_d = stop_st;
      ST_SSTOP:  if (bottom_hit) st_d = ST_OFF;
      ST_OFF:    if (!power_on_req) st_d = ST_IDLE;
      default:   st_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_RESET;
    else        st_q <= st_d;
  end

  assign tick_clr  = ((st_q != ST_SSTART) && (st_q != ST_SSTOP)) || fast_act;
  assign ramp_up   = (st_q == ST_SSTART) && !fast_act;
  assign ramp_dn   = (st_q == ST_SSTOP);
  assign ramp_zero = fast_act || (st_d == ST_RESET) || (st_d == ST_LOAD) ||
                     (st_d == ST_IDLE) || (st_d == ST_OFF);

  pwr_seq_tick #(.DW(DW)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr), .div(tick_div), .tick(tick)
  );

  pwr_seq_ramp #(.RW(RW)) u_ramp (
    .clk(clk), .rst_n(rst_n), .zero(ramp_zero), .up(ramp_up), .down(ramp_dn),
    .tick(tick), .target(ref_target), .step(ref_step), .ref_o(ref_out),
    .top_hit(top_hit), .bottom_hit(bottom_hit)
  );

  assign pwm_en    = (st_q == ST_SSTART) || (st_q == ST_RUN) || (st_q == ST_SSTOP);
  assign seq_state = st_q;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int RW = 12,
  parameter int NT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          power_on_req,
  input logic [2:0]    st,
  input logic [RW-1:0] ref_out,
  input logic          fast_act,
  input logic          shut_evt,
  input logic [NT-1:0] flag_now,
  input logic [NT-1:0] flag_latched
);
  // R1
  reset_to_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd0 |=> st == 3'd1);

  // R4
  fast_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_act |=> (st == 3'd3) && (ref_out == '0));

  // R3
  ramp_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3) && !fast_act && power_on_req |=> ref_out >= $past(ref_out));

  // R6
  ss_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3) && power_on_req |=> (st == 3'd3) || (st == 3'd4));

  // R7
  run_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shut_evt |=> (st == 3'd5) || (st == 3'd6));

  // R8
  off_ref_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd6 |-> ref_out == '0);

  // R10
  latch_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_latched & $past(flag_now)) == $past(flag_now));
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.RW(RW), .NT(NT)) u_chk (
  .clk(clk), .rst_n(rst_n), .power_on_req(power_on_req), .st(st_q),
  .ref_out(ref_out), .fast_act(fast_act), .shut_evt(shut_evt),
  .flag_now(flag_now), .flag_latched(flag_latched)
);

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int RW = 12, DW = 8, NF = 4, NT = NF + 2;
  localparam int TGT = 100, STP = 30, DIV = 3;
  // ceil(100/30)=4 ticks of DIV+1 clocks
  localparam int RAMP_CYC = 4 * (DIV + 1);

  logic clk = 0, rst_n = 0;
  logic load_done = 0, power_on_req = 0, soft_stop_en = 0, fast_ocp_blank = 0;
  logic [RW-1:0] ref_target = TGT[RW-1:0], ref_step = STP[RW-1:0];
  logic [DW-1:0] tick_div = DIV[DW-1:0];
  logic fast_ocp = 0, ext_fault = 0, lat_clr = 0;
  logic [NF-1:0] int_flags = '0;
  logic [NT-1:0] flag_ignore = 6'b000100, flag_shutdown = 6'b101100;
  logic [RW-1:0] ref_out;
  logic pwm_en;
  logic [2:0] seq_state;
  logic [NT-1:0] flag_now, flag_latched;

  int checks = 0, errors = 0;
  int ref_at_poke, ref_after_poke;

  always #5 clk = ~clk;

  pwr_seq_ctrl #(.RW(RW), .DW(DW), .NF(NF)) dut (
    .clk(clk), .rst_n(rst_n), .load_done(load_done), .power_on_req(power_on_req),
    .soft_stop_en(soft_stop_en), .fast_ocp_blank(fast_ocp_blank),
    .ref_target(ref_target), .ref_step(ref_step), .tick_div(tick_div),
    .fast_ocp(fast_ocp), .int_flags(int_flags), .ext_fault(ext_fault),
    .flag_ignore(flag_ignore), .flag_shutdown(flag_shutdown), .lat_clr(lat_clr),
    .ref_out(ref_out), .pwm_en(pwm_en), .seq_state(seq_state),
    .flag_now(flag_now), .flag_latched(flag_latched)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Count consecutive negedges in state st; poke kind 1 = shutdown flag, 2 = fast OCP,
  // held for the single cycle with index p.
  task automatic count_state(input int st, input int kind, input int p, output int n);
    n = 0;
    while (seq_state == st[2:0] && n < 1000) begin
      if (n == p) begin
        ref_at_poke = int'(ref_out);
        if (kind == 1) int_flags = 4'b0100;
        if (kind == 2) fast_ocp = 1'b1;
      end
      if (n == p + 1) begin
        ref_after_poke = int'(ref_out);
        int_flags = 4'b0000;
        fast_ocp = 1'b0;
      end
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 state in reset", seq_state, 0);
    chk("R1 ref in reset", ref_out, 0);
    chk("R12 pwm in reset", pwm_en, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 waits in LOAD", seq_state, 1);
  endtask

  task automatic t_load_idle_ramp;
    int n;
    load_done = 1;
    @(negedge clk);
    chk("R2 load to IDLE", seq_state, 2);
    chk("R12 pwm in IDLE", pwm_en, 0);
    power_on_req = 1;
    @(negedge clk);
    chk("R12 pwm in SOFT_START", pwm_en, 1);
    count_state(3, 0, -5, n);
    chk("R3 soft start clocks", n, RAMP_CYC);
    chk("R3 RUN reached", seq_state, 4);
    chk("R3 ref at target", ref_out, TGT);
    chk("R12 pwm in RUN", pwm_en, 1);
  endtask

  task automatic t_flags_run;
    int_flags = 4'b0011;
    repeat (3) @(negedge clk);
    chk("R7 report-only keeps RUN", seq_state, 4);
    chk("R9 ignored flag masked", flag_now, 6'b000010);
    chk("R10 latched set", flag_latched, 6'b000010);
    int_flags = 4'b0001;
    lat_clr = 1;
    @(negedge clk);
    lat_clr = 0;
    @(negedge clk);
    chk("R10 clear keeps present flag", flag_latched, 6'b000010);
    int_flags = 4'b0000;
    @(negedge clk);
    chk("R10 sticky after removal", flag_latched, 6'b000010);
    lat_clr = 1;
    @(negedge clk);
    lat_clr = 0;
    chk("R10 clear after removal", flag_latched, 0);
  endtask

  task automatic t_soft_stop_fault;
    int n;
    soft_stop_en = 1;
    int_flags = 4'b0100;
    @(negedge clk);
    chk("R7 shutdown flag to SOFT_STOP", seq_state, 5);
    chk("R12 pwm in SOFT_STOP", pwm_en, 1);
    count_state(5, 0, -5, n);
    chk("R8 soft stop same duration", n, RAMP_CYC);
    chk("R8 OFF after soft stop", seq_state, 6);
    chk("R8 ref zero in OFF", ref_out, 0);
    chk("R12 pwm in OFF", pwm_en, 0);
    @(negedge clk);
    chk("R13 OFF held while requested", seq_state, 6);
    int_flags = 4'b0000;
    power_on_req = 0;
    @(negedge clk);
    chk("R13 OFF to IDLE", seq_state, 2);
  endtask

  task automatic t_ss_masked;
    int n;
    power_on_req = 1;
    @(negedge clk);
    count_state(3, 1, 5, n);
    chk("R6 other flag ignored in ramp", n, RAMP_CYC);
    chk("R6 RUN reached", seq_state, 4);
    soft_stop_en = 0;
    power_on_req = 0;
    @(negedge clk);
    chk("R8 direct OFF without soft stop", seq_state, 6);
    chk("R8 ref zero direct OFF", ref_out, 0);
    @(negedge clk);
    chk("R13 back to IDLE", seq_state, 2);
  endtask

  task automatic t_fast_ocp;
    int n;
    power_on_req = 1;
    @(negedge clk);
    count_state(3, 2, 9, n);
    chk("R4 ref before fast OCP", ref_at_poke, 60);
    chk("R4 ref zero after fast OCP", ref_after_poke, 0);
    chk("R4 ramp restarted", n, 10 + RAMP_CYC);
    chk("R4 RUN after restart", seq_state, 4);
    soft_stop_en = 1;
    power_on_req = 0;
    @(negedge clk);
    chk("R8 power-off to SOFT_STOP", seq_state, 5);
    count_state(5, 0, -5, n);
    chk("R8 power-off soft stop clocks", n, RAMP_CYC);
    @(negedge clk);
    chk("R13 IDLE again", seq_state, 2);
    fast_ocp_blank = 1;
    power_on_req = 1;
    @(negedge clk);
    count_state(3, 2, 9, n);
    chk("R5 blanked fast OCP", n, RAMP_CYC);
    fast_ocp_blank = 0;
  endtask

  task automatic t_ext_fault;
    soft_stop_en = 0;
    ext_fault = 1;
    @(negedge clk);
    chk("R11 external fault shuts down", seq_state, 6);
    chk("R11 external flag present", flag_now, 6'b100000);
    @(negedge clk);
    chk("R11 external flag latched", int'(flag_latched[5]), 1);
    ext_fault = 0;
  endtask

  task automatic t_load_direct;
    rst_n = 0;
    load_done = 0;
    power_on_req = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 LOAD after reset", seq_state, 1);
    load_done = 1;
    @(negedge clk);
    chk("R2 load to SOFT_START directly", seq_state, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_load_idle_ramp();
    t_flags_run();
    t_soft_stop_fault();
    t_ss_masked();
    t_fast_ocp();
    t_ext_fault();
    t_load_direct();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule